// File: doc/BRIEF.md
# Interrupt Acceptance Mask Filter

This block decides whether a single pending interrupt request may be taken. A request carries a 4-bit priority level, a source index and an NMI marker. An ordinary request is accepted only when three conditions all hold. Its level must be strictly above a software-programmed user mask level. Its level must also be strictly above the processor status mask level, which arrives on a pin. Finally, the enable bit of its source must not be set in the per-source mask vector. An NMI request skips all three tests and is always accepted.

Requests enter on a valid/ready stream. Each request that handshakes produces exactly one result, one cycle later, on a valid/ready output stream. The result carries the accept decision, the request's level and its NMI marker. The output stage holds a single entry. `req_ready` is high when that entry is empty or is being drained in the same cycle, so back-pressure on `res_ready` stalls the input at once. The masks are sampled in the cycle the request handshakes.

A small register port gives software access to two registers. One is the user mask register, which holds the 4-bit level. The other is the NMI status register, which holds a sticky flag that hardware sets whenever an NMI request handshakes. Software clears the flag by writing 0 to it.

Top module: `intc_accept_filter`

## Requirements
- R1: A non-NMI request whose level is less than or equal to the user mask level gives a result with `res_accept` = 0.
- R2: With the user mask level at 0xF, every non-NMI request is rejected, whatever its level, source or the status mask level.
- R3: A non-NMI request whose source has its bit set to 1 in `src_mask` is rejected, even when its level passes both level tests. A bit at 0 enables the source.
- R4: A non-NMI request is accepted only if its level is strictly greater than `sr_mask`. It is accepted when it also passes R1 and R3.
- R5: An NMI request (`req_nmi` = 1) always gives `res_accept` = 1, and `res_nmi` = 1. In every result, `res_level` equals the request's level.
- R6: Results, accepted or not, never change the user mask level. Only a register write with `reg_sel` = 0 changes it.
- R7: After reset, the user mask register reads 0x00000000, the NMI status register reads 0x00000000, and `res_valid` is 0.
- R8: Hardware sets the NMI flag in the cycle after an NMI request handshakes. The flag reads as bit 16 of the NMI status register (`reg_sel` = 1).
- R9: A write to the NMI status register with bit 16 = 0 clears the flag. A write with bit 16 = 1 leaves the flag as it is. If an NMI handshake and a clearing write fall in the same cycle, the flag ends up set.
- R10: `reg_rdata` is combinational from `reg_sel`. With `reg_sel` = 0, bits [7:4] hold the user mask level and all other bits read 0. A write with `reg_sel` = 0 takes the level from `reg_wdata[7:4]` and ignores the other bits. With `reg_sel` = 1, bits [15:0] and every bit other than 16 read 0.
- R11: `req_ready` = !`res_valid` || `res_ready`. While `res_valid` = 1 and `res_ready` = 0, the result holds steady. Each request handshake gives exactly one result, in order, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sr_mask | input | 4 | Processor status mask level |
| src_mask | input | NUM_SRC | Per-source mask bits, 1 = masked |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_nmi | input | 1 | Request is an NMI |
| req_src | input | SRC_W | Request source index |
| req_level | input | 4 | Request priority level |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result ready |
| res_accept | output | 1 | Request accepted |
| res_nmi | output | 1 | Result belongs to an NMI |
| res_level | output | 4 | Level of the request |
| reg_sel | input | 1 | Register select: 0 user mask, 1 NMI status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The assertions check on every cycle that:
- the user mask level moves only on its own register write;
- an NMI handshake always leaves the flag set;
- a write of 1 never clears the flag;
- a clearing write with no NMI does clear it;
- a stalled result holds steady;
- every NMI result is an accept.

The bench scenarios show the parts the assertions cannot see:
- the three-way decision for chosen levels, including the equal-level and 0xF boundaries;
- the source mask;
- the register read layout and reset values;
- the case where setting the flag wins over clearing it;
- the one-to-one ordering of results under back-pressure.

// File: rtl/intc_accept_pkg.sv
package intc_accept_pkg;
  localparam int LVL_W     = 4;
  localparam int DATA_W    = 32;
  localparam int UMASK_LSB = 4;
  localparam int NMI_BIT   = 16;

  localparam logic SEL_UMASK = 1'b0;
  localparam logic SEL_NMI   = 1'b1;

  typedef struct packed {
    logic             accept;
    logic             nmi;
    logic [LVL_W-1:0] level;
  } acc_res_t;
endpackage

// File: rtl/intc_mask_regs.sv
module intc_mask_regs
  import intc_accept_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              nmi_evt,
  output logic [LVL_W-1:0]  umask
);
  logic nmi_flag;
  logic wr_umask, wr_nmi_clr;
  logic unused_wbits;

  assign wr_umask   = wr_en && (sel == SEL_UMASK);
  assign wr_nmi_clr = wr_en && (sel == SEL_NMI) && !wr_data[NMI_BIT];
  assign unused_wbits = ^{wr_data[DATA_W-1:NMI_BIT+1],
                          wr_data[NMI_BIT-1:UMASK_LSB+LVL_W],
                          wr_data[UMASK_LSB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) umask <= '0;
    else if (wr_umask) umask <= wr_data[UMASK_LSB +: LVL_W];
  end

  // hardware set dominates a software clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_flag <= 1'b0;
    else if (nmi_evt) nmi_flag <= 1'b1;
    else if (wr_nmi_clr) nmi_flag <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    if (sel == SEL_UMASK) rd_data[UMASK_LSB +: LVL_W] = umask;
    else rd_data[NMI_BIT] = nmi_flag;
  end

  // R6
  umask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_umask |=> $stable(umask));
  // R8
  nmi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_evt |=> nmi_flag);
  // R9
  nmi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_flag && !wr_nmi_clr) |=> nmi_flag);
  // R9
  nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_nmi_clr && !nmi_evt) |=> !nmi_flag);
endmodule

// File: rtl/intc_mask_eval.sv
module intc_mask_eval
  import intc_accept_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               nmi,
  input  logic [LVL_W-1:0]   level,
  input  logic [SRC_W-1:0]   src,
  input  logic [LVL_W-1:0]   umask,
  input  logic [LVL_W-1:0]   srmask,
  input  logic [NUM_SRC-1:0] src_mask,
  output logic               accept
);
  logic src_en, above_user, above_sr;

  always_comb begin
    src_en = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (src == SRC_W'(i)) src_en = !src_mask[i];
  end

  assign above_user = level > umask;
  assign above_sr   = level > srmask;
  assign accept     = nmi || (above_user && above_sr && src_en);
endmodule

// File: rtl/intc_out_stage.sv
module intc_out_stage
  import intc_accept_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  acc_res_t in_data,
  output logic     out_valid,
  input  logic     out_ready,
  output acc_res_t out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/intc_accept_filter.sv
module intc_accept_filter
  import intc_accept_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         sr_mask,
  input  logic [NUM_SRC-1:0] src_mask,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_nmi,
  input  logic [SRC_W-1:0]   req_src,
  input  logic [3:0]         req_level,
  output logic               res_valid,
  input  logic               res_ready,
  output logic               res_accept,
  output logic               res_nmi,
  output logic [3:0]         res_level,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata
);
  logic [LVL_W-1:0] umask;
  logic             acc;
  logic             nmi_evt;
  acc_res_t         stage_in, stage_out;

  assign nmi_evt = req_valid && req_ready && req_nmi;

  intc_mask_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel),
    .wr_data(reg_wdata), .rd_data(reg_rdata), .nmi_evt(nmi_evt), .umask(umask)
  );

  intc_mask_eval #(.NUM_SRC(NUM_SRC)) u_eval (
    .nmi(req_nmi), .level(req_level), .src(req_src), .umask(umask),
    .srmask(sr_mask), .src_mask(src_mask), .accept(acc)
  );

  assign stage_in = '{accept: acc, nmi: req_nmi, level: req_level};

  intc_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_ready(req_ready),
    .in_data(stage_in), .out_valid(res_valid), .out_ready(res_ready),
    .out_data(stage_out)
  );

  assign res_accept = stage_out.accept;
  assign res_nmi    = stage_out.nmi;
  assign res_level  = stage_out.level;

  // R5
  nmi_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_nmi) |-> res_accept);
  // R2
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_nmi && umask == 4'hF) |=> !res_accept);
endmodule

// File: tb/intc_accept_filter_test.sv
`timescale 1ns/1ps
module intc_accept_filter_test;
  localparam int NUM_SRC = 8;
  localparam int SRC_W = 3;

  logic clk = 0, rst_n = 0;
  logic [3:0] sr_mask = 0;
  logic [NUM_SRC-1:0] src_mask = 0;
  logic req_valid = 0, req_nmi = 0;
  logic req_ready;
  logic [SRC_W-1:0] req_src = 0;
  logic [3:0] req_level = 0;
  logic res_valid, res_accept, res_nmi;
  logic res_ready = 1;
  logic [3:0] res_level;
  logic reg_sel = 0, reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  int total = 0, bad = 0;
  logic [3:0] m_umask = 0;
  logic [5:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  intc_accept_filter #(.NUM_SRC(NUM_SRC)) uut (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic nmi, input logic [SRC_W-1:0] src, input logic [3:0] lvl, input string tag);
    logic a;
    @(posedge clk); #2;
    req_valid = 1; req_nmi = nmi; req_src = src; req_level = lvl;
    forever begin
      @(negedge clk);
      if (req_ready) begin
        a = nmi || (lvl > m_umask && lvl > sr_mask && !src_mask[src]);
        exp_q.push_back({a, nmi, lvl});
        tag_q.push_back(tag);
        break;
      end
    end
    @(posedge clk); #2;
    req_valid = 0;
  endtask

  task automatic wr_reg(input logic sel, input logic [31:0] d);
    @(posedge clk); #2;
    reg_sel = sel; reg_wr = 1; reg_wdata = d;
    if (sel == 0) m_umask = d[7:4];
    @(posedge clk); #2;
    reg_wr = 0;
  endtask

  task automatic rd_chk(input logic sel, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    reg_sel = sel; #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  // monitor: a handshake at the coming edge is visible at this negedge
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected result", {26'd0, res_accept, res_nmi, res_level}, 0);
      else begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({res_accept, res_nmi, res_level} === e, t, {26'd0, res_accept, res_nmi, res_level}, {26'd0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] held;
    repeat (3) @(posedge clk); #2;
    rst_n = 1;
    // R7 reset state
    chk(res_valid === 1'b0, "R7 res_valid", res_valid, 0);
    rd_chk(0, 32'h0, "R7 umask reset");
    rd_chk(1, 32'h0, "R7 nmi reset");

    send(0, 1, 4'd5, "R4 accept lvl5");
    send(0, 1, 4'd0, "R1 equal lvl0 masked");
    // R10 write with noise in other bits
    wr_reg(0, 32'hFFFF_FF7F);
    rd_chk(0, 32'h0000_0070, "R10 umask layout");
    send(0, 0, 4'd7, "R1 equal lvl7 masked");
    send(0, 0, 4'd3, "R1 below masked");
    send(0, 0, 4'd8, "R1 above accepted");

    sr_mask = 4'd9;
    send(0, 4, 4'd8, "R4 below sr masked");
    send(0, 4, 4'd9, "R4 equal sr masked");
    send(0, 4, 4'd10, "R4 above sr accepted");

    src_mask = 8'b0000_0100;
    send(0, 2, 4'd12, "R3 source masked");
    send(0, 3, 4'd12, "R3 source enabled");

    sr_mask = 4'd0; src_mask = 0;
    wr_reg(0, 32'h0000_00F0);
    send(0, 5, 4'd15, "R2 full mask lvl15");
    send(0, 6, 4'd1, "R2 full mask lvl1");
    rd_chk(1, 32'h0, "R8 flag clear before nmi");
    src_mask = 8'hFF; sr_mask = 4'hF;
    send(1, 2, 4'd15, "R5 nmi accepted");
    send(1, 0, 4'd0, "R5 nmi lvl0 accepted");
    src_mask = 0; sr_mask = 0;
    rd_chk(0, 32'h0000_00F0, "R6 umask unchanged");
    rd_chk(1, 32'h0001_0000, "R8 flag set");

    wr_reg(1, 32'hFFFF_FFFF);
    rd_chk(1, 32'h0001_0000, "R9 write one ignored");
    wr_reg(1, 32'hFFFE_FFFF);
    rd_chk(1, 32'h0, "R9 write zero clears");
    fork
      send(1, 1, 4'd2, "R5 nmi during clear");
      wr_reg(1, 32'h0);
    join
    rd_chk(1, 32'h0001_0000, "R9 set wins over clear");

    // R11 back-pressure
    wr_reg(0, 32'h0);
    @(posedge clk); #2; res_ready = 0;
    send(0, 1, 4'd6, "R11 result after stall");
    @(negedge clk);
    chk(res_valid === 1'b1, "R11 valid during stall", res_valid, 1);
    chk(req_ready === 1'b0, "R11 ready low during stall", req_ready, 0);
    held = {res_accept, res_nmi, res_level};
    repeat (3) @(negedge clk);
    chk({res_accept, res_nmi, res_level} === held, "R11 held stable", {26'd0, res_accept, res_nmi, res_level}, {26'd0, held});
    @(posedge clk); #2; res_ready = 1;
    send(0, 1, 4'd9, "R11 next in order");
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule